// File: doc/BRIEF.md
# Frequency Lock Monitor with Reference Fallback and Polling

This block decides whether a valid serial channel is present by looking only at the frequency of the recovered clock. A pulse train derived from the recovered clock is divided down to the nominal reference rate. Those divided pulses are counted over a gate window that lasts a fixed number of reference ticks. When the count lies within a tolerance of the window length, the frequencies agree. Both clocks arrive as single-cycle enable pulses in one clock domain. The divide ratio follows a rate-select input: 10 for the full-rate reference and 20 for the half-rate reference, against a 1.0625 Gb/s line.

The block drives two outputs. `lock_det` flags a present channel. `follow_data` tells the clock-recovery loop to track the incoming data (1) or the local reference (0). The controller has three states:
- REF_LOCK: the loop follows the reference, and the controller counts a programmable number of idle windows.
- POLL: the loop follows the data, one or more settling windows are discarded, and the next window is judged.
- LOCKED: the channel is declared present, and every window is re-judged.

The transitions are:
- WAIT_DONE: REF_LOCK to POLL.
- POLL_PASS: POLL to LOCKED.
- POLL_FAIL: POLL to REF_LOCK.
- DRIFT: LOCKED to REF_LOCK.
- RATE_CHANGE: any state to REF_LOCK.

Top module: `freq_lock_monitor`

## Requirements
- R1: A synchronous active-low reset puts the controller in REF_LOCK, clears every counter, and holds `lock_det` and `follow_data` at 0.
- R2: A `rec_tick` pulse is divided by DIV_FAST (10) while `ref_half`=0 and by DIV_SLOW (20) while `ref_half`=1. The same line rate then yields the expected count under either reference.
- R3: A gate window lasts 2^WIN_LOG2 `ref_tick` pulses. A window passes when the divided count differs from 2^WIN_LOG2 by at most TOL (100 ppm at the default window of 2^16).
- R4: In REF_LOCK, `follow_data`=0 and `lock_det`=0. After POLL_GAP complete windows, the controller takes WAIT_DONE to POLL.
- R5: In POLL, `follow_data`=1 and `lock_det`=0. The first SETTLE windows are ignored whatever their count. The next window takes POLL_PASS to LOCKED if it passes, or POLL_FAIL to REF_LOCK if it fails.
- R6: In LOCKED, `lock_det`=1 and `follow_data`=1. A failing window takes DRIFT back to REF_LOCK, so both outputs drop.
- R7: `lock_det` is registered and changes only on the cycle after a window ends, after a rate change, or after reset. It never changes in the middle of a window.
- R8: A change of `ref_half` clears the divider, window and count registers. It takes RATE_CHANGE to REF_LOCK, and both outputs read 0 from the next cycle.
- R9: An absent recovered clock, a fast one, and a slow one (for example one pulse in 16 missing) each fail a window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ref_half | input | 1 | 0: full-rate reference, 1: half-rate reference |
| ref_tick | input | 1 | One pulse per reference clock period |
| rec_tick | input | 1 | One pulse per recovered serial clock period |
| lock_det | output | 1 | Channel present (state LOCKED) |
| follow_data | output | 1 | 1: loop tracks data, 0: loop tracks reference |

## Verification
A corrupted state or wait counter shows at the ports no later than the next window boundary. In that case `follow_data` rises after the wrong number of idle windows, or `lock_det` rises without a preceding poll. A count or divide fault shows as a wrong lock decision one or two windows after the stimulus frequency changes. A missed clear on a rate change shows within a few cycles, as an output that stays high after `ref_half` toggles. Sampling near both the start and the end of each window also exposes any lock flag that moves mid-window.

// File: rtl/fld_pkg.sv
package fld_pkg;

    typedef enum logic [1:0] {
        ST_REF_LOCK = 2'd0,
        ST_POLL     = 2'd1,
        ST_LOCKED   = 2'd2
    } fld_state_e;

endpackage

// File: rtl/fld_rx_divider.sv
// Divides the recovered-clock pulse train down to reference rate (R2).
module fld_rx_divider #(
    parameter int DIV_FAST = 10,
    parameter int DIV_SLOW = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic half_rate,
    input  logic rec_tick,
    output logic div_tick
);
    localparam int MAXDIV = (DIV_SLOW > DIV_FAST) ? DIV_SLOW : DIV_FAST;
    localparam int CW     = $clog2(MAXDIV + 1);

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] limit;

    always_comb begin
        limit = half_rate ? CW'(DIV_SLOW - 1) : CW'(DIV_FAST - 1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt_q    <= '0;
            div_tick <= 1'b0;
        end else begin
            div_tick <= 1'b0;
            if (rec_tick) begin
                if (cnt_q >= limit) begin
                    cnt_q    <= '0;
                    div_tick <= 1'b1;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/fld_gate_timer.sv
// Counts reference ticks; flags the last tick of each window (R3).
module fld_gate_timer #(
    parameter int WIN_LOG2 = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic ref_tick,
    output logic win_end
);
    logic [WIN_LOG2-1:0] tick_q;

    always_comb begin
        win_end = ref_tick && (tick_q == '1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            tick_q <= '0;
        end else if (ref_tick) begin
            tick_q <= tick_q + 1'b1;
        end
    end
endmodule

// File: rtl/fld_edge_counter.sv
// Counts divided pulses inside a window and judges the tolerance (R3, R9).
module fld_edge_counter #(
    parameter int WIN_LOG2 = 16,
    parameter int TOL      = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic div_tick,
    input  logic win_end,
    output logic in_tol
);
    localparam int CW  = WIN_LOG2 + 2;
    localparam int EXP = 2 ** WIN_LOG2;
    localparam logic [CW-1:0] HI_LIM = CW'(EXP + TOL);
    localparam logic [CW-1:0] LO_LIM = CW'((EXP > TOL) ? (EXP - TOL) : 0);

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] total;

    always_comb begin
        if (cnt_q == '1) begin
            total = cnt_q;
        end else begin
            total = cnt_q + {{(CW-1){1'b0}}, div_tick};
        end
        in_tol = (total >= LO_LIM) && (total <= HI_LIM);
    end

    always_ff @(posedge clk) begin
        if (!rst_n || clr || win_end) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= total;
        end
    end
endmodule

// File: rtl/freq_lock_monitor.sv
module freq_lock_monitor
    import fld_pkg::*;
#(
    parameter int WIN_LOG2 = 16,
    parameter int TOL      = 6,
    parameter int DIV_FAST = 10,
    parameter int DIV_SLOW = 20,
    parameter int POLL_GAP = 4,
    parameter int SETTLE   = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ref_half,
    input  logic ref_tick,
    input  logic rec_tick,
    output logic lock_det,
    output logic follow_data
);
    localparam int GW = (POLL_GAP > 1) ? $clog2(POLL_GAP) : 1;
    localparam int SW = (SETTLE > 0) ? $clog2(SETTLE + 1) : 1;

    fld_state_e    state_q, state_d;
    logic [GW-1:0] wait_q, wait_d;
    logic [SW-1:0] settle_q, settle_d;
    logic          sel_q;
    logic          sel_chg;
    logic          div_tick;
    logic          win_end;
    logic          in_tol;

    // Rate-select change detection (R8)
    always_ff @(posedge clk) begin
        sel_q <= ref_half;
    end

    always_comb begin
        sel_chg = rst_n && (ref_half != sel_q);
    end

    fld_rx_divider #(.DIV_FAST(DIV_FAST), .DIV_SLOW(DIV_SLOW)) u_div (
        .clk(clk), .rst_n(rst_n), .clr(sel_chg),
        .half_rate(ref_half), .rec_tick(rec_tick), .div_tick(div_tick)
    );

    fld_gate_timer #(.WIN_LOG2(WIN_LOG2)) u_gate (
        .clk(clk), .rst_n(rst_n), .clr(sel_chg),
        .ref_tick(ref_tick), .win_end(win_end)
    );

    fld_edge_counter #(.WIN_LOG2(WIN_LOG2), .TOL(TOL)) u_cnt (
        .clk(clk), .rst_n(rst_n), .clr(sel_chg),
        .div_tick(div_tick), .win_end(win_end), .in_tol(in_tol)
    );

    // Next-state logic (R4, R5, R6, R8)
    always_comb begin
        state_d  = state_q;
        wait_d   = wait_q;
        settle_d = settle_q;
        if (sel_chg) begin
            state_d  = ST_REF_LOCK;          // RATE_CHANGE
            wait_d   = '0;
            settle_d = '0;
        end else if (win_end) begin
            unique case (state_q)
                ST_REF_LOCK: begin
                    if (wait_q == GW'(POLL_GAP - 1)) begin
                        state_d  = ST_POLL;  // WAIT_DONE
                        wait_d   = '0;
                        settle_d = '0;
                    end else begin
                        wait_d = wait_q + 1'b1;
                    end
                end
                ST_POLL: begin
                    if (settle_q < SW'(SETTLE)) begin
                        settle_d = settle_q + 1'b1;
                    end else if (in_tol) begin
                        state_d = ST_LOCKED; // POLL_PASS
                    end else begin
                        state_d = ST_REF_LOCK; // POLL_FAIL
                        wait_d  = '0;
                    end
                end
                ST_LOCKED: begin
                    if (!in_tol) begin
                        state_d = ST_REF_LOCK; // DRIFT
                        wait_d  = '0;
                    end
                end
                default: begin
                    state_d = ST_REF_LOCK;
                    wait_d  = '0;
                end
            endcase
        end
    end

    // State register (R1)
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_REF_LOCK;
            wait_q   <= '0;
            settle_q <= '0;
        end else begin
            state_q  <= state_d;
            wait_q   <= wait_d;
            settle_q <= settle_d;
        end
    end

    // Registered outputs (R7)
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lock_det    <= 1'b0;
            follow_data <= 1'b0;
        end else begin
            lock_det    <= (state_d == ST_LOCKED);
            follow_data <= (state_d != ST_REF_LOCK);
        end
    end
endmodule

// File: rtl/fld_checker.sv
module fld_checker (
    input logic clk,
    input logic rst_n,
    input logic lock_det,
    input logic follow_data,
    input logic win_end,
    input logic sel_chg
);
    logic seen_rst = 1'b0;

    always_ff @(posedge clk) begin
        if (!rst_n) seen_rst <= 1'b1;
    end

    assert_reset_clear_R1: assert property (@(posedge clk) disable iff (!seen_rst)
        $past(!rst_n) |-> (!lock_det && !follow_data));

    assert_poll_start_R4: assert property (@(posedge clk) disable iff (!rst_n || !seen_rst)
        $rose(follow_data) |-> ($past(win_end) && !lock_det));

    assert_lock_from_poll_R5: assert property (@(posedge clk) disable iff (!rst_n || !seen_rst)
        $rose(lock_det) |-> $past(follow_data));

    assert_lock_follows_R6: assert property (@(posedge clk) disable iff (!rst_n || !seen_rst)
        lock_det |-> follow_data);

    assert_lock_at_boundary_R7: assert property (@(posedge clk) disable iff (!rst_n || !seen_rst)
        !$stable(lock_det) |-> ($past(win_end) || $past(sel_chg) || $past(!rst_n)));

    assert_rate_change_R8: assert property (@(posedge clk) disable iff (!rst_n || !seen_rst)
        $past(sel_chg) |-> (!lock_det && !follow_data));
endmodule

bind freq_lock_monitor fld_checker u_fld_checker (
    .clk(clk),
    .rst_n(rst_n),
    .lock_det(lock_det),
    .follow_data(follow_data),
    .win_end(win_end),
    .sel_chg(sel_chg)
);

// File: tb/test_freq_lock_monitor.sv
module test_freq_lock_monitor;
    localparam int WIN = 64;

    typedef struct packed {
        logic [7:0] period;
        logic [7:0] skip;
        logic       on;
        logic       ef;
        logic       el;
    } vec_t;

    // Each entry is one window at ref_half=0: stimulus, and the state shown during it.
    localparam vec_t VECS [21] = '{
        '{8'd10, 8'd0,  1'b1, 1'b0, 1'b0},
        '{8'd10, 8'd0,  1'b1, 1'b0, 1'b0},
        '{8'd10, 8'd0,  1'b1, 1'b1, 1'b0},
        '{8'd10, 8'd0,  1'b1, 1'b1, 1'b0},
        '{8'd10, 8'd0,  1'b1, 1'b1, 1'b1},
        '{8'd10, 8'd64, 1'b1, 1'b1, 1'b1},
        '{8'd10, 8'd0,  1'b0, 1'b1, 1'b1},
        '{8'd10, 8'd0,  1'b0, 1'b0, 1'b0},
        '{8'd10, 8'd0,  1'b1, 1'b0, 1'b0},
        '{8'd10, 8'd0,  1'b0, 1'b1, 1'b0},
        '{8'd10, 8'd0,  1'b1, 1'b1, 1'b0},
        '{8'd12, 8'd0,  1'b1, 1'b1, 1'b1},
        '{8'd10, 8'd0,  1'b1, 1'b0, 1'b0},
        '{8'd10, 8'd0,  1'b1, 1'b0, 1'b0},
        '{8'd10, 8'd0,  1'b1, 1'b1, 1'b0},
        '{8'd10, 8'd16, 1'b1, 1'b1, 1'b0},
        '{8'd10, 8'd0,  1'b1, 1'b0, 1'b0},
        '{8'd10, 8'd0,  1'b1, 1'b0, 1'b0},
        '{8'd10, 8'd0,  1'b1, 1'b1, 1'b0},
        '{8'd10, 8'd0,  1'b1, 1'b1, 1'b0},
        '{8'd10, 8'd0,  1'b1, 1'b1, 1'b1}
    };

    logic clk = 1'b0;
    logic rst_n, ref_half, ref_tick, rec_tick;
    logic lock_det, follow_data;
    int   checks = 0;
    int   errors = 0;
    int   cyc = 0;
    bit   done = 1'b0;

    always #10 clk = ~clk;

    freq_lock_monitor #(
        .WIN_LOG2(6), .TOL(2), .DIV_FAST(10), .DIV_SLOW(20),
        .POLL_GAP(2), .SETTLE(1)
    ) i_freq_lock_monitor (
        .clk(clk), .rst_n(rst_n), .ref_half(ref_half),
        .ref_tick(ref_tick), .rec_tick(rec_tick),
        .lock_det(lock_det), .follow_data(follow_data)
    );

    task automatic chk(string tag, string what, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0b expected=%0b t=%0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic run_window(int period, int skip, bit on, bit ef, bit el, string tag);
        for (int t = 0; t < WIN; t++) begin
            for (int c = 0; c < period; c++) begin
                @(negedge clk);
                if (c == 0 && (t == 8 || t == 56)) begin
                    chk(tag, "follow_data", follow_data, ef);
                    chk(tag, (t == 56) ? "lock_det late in window R7" : "lock_det", lock_det, el);
                end
                ref_tick = (c == period - 1);
                rec_tick = on && !(skip != 0 && (cyc % skip) == 0);
                cyc++;
            end
        end
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            ref_tick = 1'b0;
            rec_tick = 1'b0;
        end
    endtask

    task automatic summary();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            summary();
        end
    end

    initial begin
        rst_n = 1'b0; ref_half = 1'b0; ref_tick = 1'b0; rec_tick = 1'b0;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1", "lock_det in reset", lock_det, 1'b0);
        chk("R1", "follow_data in reset", follow_data, 1'b0);
        rst_n = 1'b1;

        // R3 R4 R5 R6 R9: window table walk (entry 5 in tolerance, 11 fast, 15 slow, 6/9 absent)
        for (int i = 0; i < 21; i++) begin
            run_window(int'(VECS[i].period), int'(VECS[i].skip), VECS[i].on,
                       VECS[i].ef, VECS[i].el, $sformatf("R4 R5 R6 R9 window %0d", i));
        end

        // R8: rate change while locked
        @(negedge clk);
        ref_half = 1'b1; ref_tick = 1'b0; rec_tick = 1'b0;
        idle(3);
        chk("R8", "lock_det after rate change", lock_det, 1'b0);
        chk("R8", "follow_data after rate change", follow_data, 1'b0);

        // R2: half-rate reference needs the divide-by-20 ratio to lock
        run_window(20, 0, 1'b1, 1'b0, 1'b0, "R2 half-rate w0");
        run_window(20, 0, 1'b1, 1'b0, 1'b0, "R2 half-rate w1");
        run_window(20, 0, 1'b1, 1'b1, 1'b0, "R2 half-rate w2");
        run_window(20, 0, 1'b1, 1'b1, 1'b0, "R2 half-rate w3");
        run_window(20, 0, 1'b1, 1'b1, 1'b1, "R2 half-rate locked");
        // full-rate stimulus under half-rate select counts half: DRIFT
        run_window(10, 0, 1'b1, 1'b1, 1'b1, "R2 wrong ratio window");
        run_window(20, 0, 1'b1, 1'b0, 1'b0, "R2 R6 lost after wrong ratio");

        // R1: reset mid-run clears counters; idle count restarts from zero
        @(negedge clk);
        rst_n = 1'b0; ref_tick = 1'b0;
        @(negedge clk);
        chk("R1", "lock_det after mid-run reset", lock_det, 1'b0);
        chk("R1", "follow_data after mid-run reset", follow_data, 1'b0);
        rst_n = 1'b1;
        run_window(20, 0, 1'b1, 1'b0, 1'b0, "R1 R4 restart w0");
        run_window(20, 0, 1'b1, 1'b0, 1'b0, "R1 R4 restart w1");
        run_window(20, 0, 1'b1, 1'b1, 1'b0, "R1 R4 restart w2");

        done = 1'b1;
        summary();
    end
endmodule